// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port that sits on a byte-wide register bus. Each pin has a direction bit and an output data bit, and the state of every pin can be read back. The data register is not a single location: it repeats across a window of word addresses, and the word address itself carries a per-pin select mask. A write changes only the pins whose select bit is set. A read shows only those pins and returns zero for all others. Software can therefore set, clear or sample any group of pins in one bus cycle, with no read-modify-write, and two agents that own different pins cannot overwrite each other's bits.

The direction register sits just above the data window. A direction bit of 1 drives the pin from the output data register and raises its output enable. A direction bit of 0 leaves the pin as an input. Pad inputs pass through a two-flop synchronizer before they can be read. Read data is registered, so `bus_rdata` shows the result for the address that was present on the previous clock edge. The bus has no handshake: every write completes in one cycle, and a read returns a result every cycle.

Top module: `gpio_masked_port`

## Requirements
- R1: While reset is asserted and after it, until the first write, every pin is an input: `pad_oe` = 0x00, `pad_out` = 0x00, `bus_rdata` = 0x00.
- R2: A write to a data-window address (byte address bit 10 = 0, bits 1:0 = 0) updates output bit n only when address bit n+2 is 1. Every other output bit keeps its value. Each single pin n can be reached at address 1 << (n+2).
- R3: A write to address 0x3FC updates all eight output bits.
- R4: A read of a data-window address returns 0 in every bit whose address select bit (bit n+2) is 0. Address 0x000 therefore always reads 0x00.
- R5: In a data read, a selected pin whose direction bit is 1 returns its output data bit. A selected pin whose direction bit is 0 returns its synchronized pad input.
- R6: Address 0x400 holds the direction register. It is read/write, a 1 in bit n makes pin n an output, and `pad_oe` always equals it.
- R7: A pad input change becomes visible in `bus_rdata` only after three rising edges: two synchronizer stages and the read register.
- R8: A write to any other address is ignored. This covers byte address bit 10 = 1 other than 0x400, and any address with bits 1:0 ≠ 0. A read of such an address returns 0x00.
- R9: `bus_rdata` is registered and reflects the address and register state from the previous rising edge.
- R10: `pad_out` always shows the output data register, whatever the direction. Data written while a pin is an input is kept and driven once the pin becomes an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Byte address; bits 9:2 form the pin select mask within the data window |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pad_in | input | 8 | Raw pad input levels (asynchronous) |
| pad_out | output | 8 | Output data register |
| pad_oe | output | 8 | Per-pin output enable (direction register) |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are driven to known values in every cycle once reset is released. They also assume that a write lasts exactly the cycle in which `bus_we` is high, so that the previous-cycle address fully explains each change on `pad_out`, `pad_oe` and `bus_rdata`. The stimulus drives all bus inputs from time zero and changes them only on falling edges. It also changes `pad_in` only on falling edges, so the synchronizer delay counted in R7 is exact and repeatable.

// File: rtl/gpio_masked_port_pkg.sv
package gpio_masked_port_pkg;

  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_DIR  = 2'd1,
    RGN_NONE = 2'd2
  } region_e;

endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/gpm_decode.sv
module gpm_decode
  import gpio_masked_port_pkg::*;
#(
  parameter int NPINS   = 8,
  parameter int SEL_LSB = 2,
  parameter int ADDR_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [NPINS-1:0]  pin_sel
);

  localparam int WORD_W = ADDR_W - SEL_LSB;
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << NPINS;

  logic [WORD_W-1:0]  word;
  logic [SEL_LSB-1:0] lane;

  assign word    = addr[ADDR_W-1:SEL_LSB];
  assign lane    = addr[SEL_LSB-1:0];
  assign pin_sel = addr[SEL_LSB+NPINS-1:SEL_LSB];

  always_comb begin
    if (lane != '0)             region = RGN_NONE;
    else if (word < DIR_WORD)   region = RGN_DATA;
    else if (word == DIR_WORD)  region = RGN_DIR;
    else                        region = RGN_NONE;
  end

endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
  import gpio_masked_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  region_e          region,
  input  logic [NPINS-1:0] pin_sel,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q
);

  logic data_wr;
  logic dir_wr;

  assign data_wr = we && (region == RGN_DATA);
  assign dir_wr  = we && (region == RGN_DIR);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     out_q[p] <= 1'b0;
      else if (data_wr && pin_sel[p]) out_q[p] <= wdata[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_wr) dir_q <= wdata;
  end

endmodule

// File: rtl/gpm_rdmux.sv
module gpm_rdmux
  import gpio_masked_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  region_e          region,
  input  logic [NPINS-1:0] pin_sel,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] pad_sync,
  output logic [NPINS-1:0] rdata
);

  logic [NPINS-1:0] pin_level;
  logic [NPINS-1:0] rd_next;

  assign pin_level = (out_q & dir_q) | (pad_sync & ~dir_q);

  always_comb begin
    unique case (region)
      RGN_DATA: rd_next = pin_level & pin_sel;
      RGN_DIR:  rd_next = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_masked_port_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int SEL_LSB  = 2,
  parameter int ADDR_W   = SEL_LSB + NPINS + 1,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  region_e          region;
  logic [NPINS-1:0] pin_sel;
  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;

  gpm_sync #(.WIDTH(NPINS), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_in),
    .d_out (pad_sync)
  );

  gpm_decode #(.NPINS(NPINS), .SEL_LSB(SEL_LSB), .ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .region  (region),
    .pin_sel (pin_sel)
  );

  gpm_regs #(.NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .region  (region),
    .pin_sel (pin_sel),
    .wdata   (bus_wdata),
    .out_q   (out_q),
    .dir_q   (dir_q)
  );

  gpm_rdmux #(.NPINS(NPINS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .region   (region),
    .pin_sel  (pin_sel),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .pad_sync (pad_sync),
    .rdata    (bus_rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int NPINS   = 8,
  parameter int SEL_LSB = 2,
  parameter int ADDR_W  = SEL_LSB + NPINS + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe
);

  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << (SEL_LSB + NPINS);

  logic             in_data;
  logic             in_dir;
  logic [NPINS-1:0] sel;
  logic [NPINS-1:0] unused_pad;

  assign in_data    = !bus_addr[ADDR_W-1] && (bus_addr[SEL_LSB-1:0] == '0);
  assign in_dir     = (bus_addr == DIR_ADDR);
  assign sel        = bus_addr[SEL_LSB+NPINS-1:SEL_LSB];
  assign unused_pad = pad_in;

  // R1: reset forces inputs and a clear output register
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  // R2: unselected output bits keep their value across a data write
  a_r2_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_data) |=>
      ((pad_out & ~$past(sel)) == ($past(pad_out) & ~$past(sel))));

  // R2: selected output bits take the written value
  a_r2_selected_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_data) |=> ((pad_out & $past(sel)) == ($past(bus_wdata) & $past(sel))));

  // R4: a data read returns zero on unselected pins
  a_r4_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |=> ((bus_rdata & ~$past(sel)) == '0));

  // R6: direction write lands in the output enables
  a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_dir) |=> (pad_oe == $past(bus_wdata)));

  // R6: direction read returns the enables as they stood
  a_r6_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && in_dir) |=> (bus_rdata == $past(pad_oe)));

  // R8: writes to unmapped offsets change nothing
  a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !in_data && !in_dir) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R8: reads of unmapped offsets return zero
  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_data && !in_dir) |=> (bus_rdata == '0));

endmodule

bind gpio_masked_port gpio_masked_port_chk #(
  .NPINS(NPINS), .SEL_LSB(SEL_LSB), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/gpio_masked_port_bench.sv
module gpio_masked_port_bench;

  localparam int NPINS  = 8;
  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [NPINS-1:0]  bus_wdata = '0;
  logic [NPINS-1:0]  bus_rdata;
  logic [NPINS-1:0]  pad_in = 8'hA5;
  logic [NPINS-1:0]  pad_out;
  logic [NPINS-1:0]  pad_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NPINS-1:0] exp;
    string            tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  logic rd_issue = 1'b0;
  logic rd_issue_q = 1'b0;

  always #2 clk = ~clk;

  gpio_masked_port u_gpio_masked_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  task automatic check(input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp,
                       input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: R9 read data is compared one edge after the address is issued
  always @(posedge clk) rd_issue_q <= rd_issue;

  always @(negedge clk) begin
    if (rd_issue_q) begin
      if (sb_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R9: read result with empty scoreboard, actual %h expected none", bus_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [NPINS-1:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [NPINS-1:0] exp,
                    input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [NPINS-1:0] acc;
    idle(3);
    check(pad_oe, 8'h00, "R1 oe in reset");
    check(pad_out, 8'h00, "R1 out in reset");
    check(bus_rdata, 8'h00, "R1 rdata in reset");
    rst_n = 1'b1;
    idle(3);
    check(pad_oe, 8'h00, "R1 oe after reset");
    rd(11'h400, 8'h00, "R1 dir reads zero after reset");

    // R6 direction register
    wr(11'h400, 8'h0F);
    check(pad_oe, 8'h0F, "R6 oe follows dir write");
    rd(11'h400, 8'h0F, "R6 dir readback");

    // R3 full-window write
    wr(11'h3FC, 8'h3C);
    check(pad_out, 8'h3C, "R3 all pins written");

    // R2 masked writes
    wr(11'h204, 8'hFF);
    check(pad_out, 8'hBD, "R2 mask 0x81 sets pins 7 and 0");
    wr(11'h010, 8'h00);
    check(pad_out, 8'hB9, "R2 single pin 2 cleared");

    // R5 mixed direction readback: (B9&0F)|(A5&F0)
    rd(11'h3FC, 8'hA9, "R5 mixed direction read");
    // R4 masked read
    rd(11'h0C0, 8'h20, "R4 mask 0x30 read");
    rd(11'h000, 8'h00, "R4 empty mask reads zero");

    // R8 unmapped and misaligned addresses
    wr(11'h404, 8'hFF);
    wr(11'h7FC, 8'hFF);
    wr(11'h3FD, 8'h00);
    wr(11'h402, 8'hF0);
    check(pad_out, 8'hB9, "R8 out untouched by unmapped writes");
    check(pad_oe, 8'h0F, "R8 oe untouched by unmapped writes");
    rd(11'h404, 8'h00, "R8 unmapped read zero");
    rd(11'h3FE, 8'h00, "R8 misaligned read zero");

    // R7 synchronizer latency with all pins as inputs
    wr(11'h400, 8'h00);
    pad_in = 8'h5A;
    rd(11'h3FC, 8'hA5, "R7 first edge still old");
    rd(11'h3FC, 8'hA5, "R7 second edge still old");
    rd(11'h3FC, 8'h5A, "R7 third edge shows new");

    // R10 data written while input is held and driven later
    wr(11'h3FC, 8'h66);
    check(pad_out, 8'h66, "R10 out register visible while input");
    rd(11'h3FC, 8'h5A, "R5 inputs read pad not out register");
    wr(11'h400, 8'hFF);
    check(pad_oe, 8'hFF, "R6 all outputs");
    rd(11'h3FC, 8'h66, "R10 retained data now driven and read");

    // R2 single-pin sweep from a cleared register
    wr(11'h3FC, 8'h00);
    acc = '0;
    for (int n = 0; n < NPINS; n++) begin
      wr(ADDR_W'(1) << (n + 2), 8'hFF);
      acc[n] = 1'b1;
      check(pad_out, acc, "R2 single pin sweep");
    end
    rd(11'h3FC, 8'hFF, "R5 outputs read back");

    idle(3);
    if (sb_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R9: %0d reads unanswered, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule